// File: doc/BRIEF.md
# Three-Bank Selectable Clock Divider

This block takes one fast chain clock and produces eleven divided clock outputs in three banks. Bank A has five outputs, bank B four and bank C two. Every output in a bank comes from a single divider, so a whole bank switches on the same chain-clock edge. Each bank has its own select pin that picks one of two even ratios. An optional divide-by-two prescaler sits in front of all three banks.

The chain clock comes from one of two sources. With `osc_en_n` low it is the oscillator clock. With `osc_en_n` high the reference clock drives the chain directly. A combined reset/output-enable input, `mr_oe`, works as follows:
- While it is high, all divider state is cleared, every output is parked low and the bank enables are deasserted.
- Once it falls, the enables rise on the next chain edge.
- Every bank output then rises together on the edge after that.

The prescaler and bank selects are captured while the block is held and frozen while it runs. A select change therefore only takes effect after the next reset release. Tri-state drivers are outside the block, so each bank has an enable bit that the pad logic uses to drive or float that bank's outputs.

Top module: `bank_clk_div`

## Requirements
- R1: All outputs of one bank carry the same value on every cycle: `qa[4:0]`, `qb[3:0]` and `qc[1:0]` are each all-zeros or all-ones.
- R2: Bank A divides the tick rate by 4 when `sel_a`=0 and by 6 when `sel_a`=1.
- R3: Bank B divides the tick rate by 4 when `sel_b`=0 and by 2 when `sel_b`=1.
- R4: Bank C divides the tick rate by 2 when `sel_c`=0 and by 4 when `sel_c`=1.
- R5: With `pre_sel`=1 a tick occurs on every second chain-clock edge, so every output period doubles. With `pre_sel`=0 every chain edge is a tick.
- R6: While `mr_oe`=1, all outputs are 0 and `oe_a`, `oe_b`, `oe_c` are 0. The enables become 1 on the first chain edge after `mr_oe` falls.
- R7: On the second chain edge after release (the first tick), every bank output goes high at once.
- R8: `pre_sel` and the bank selects are sampled while the block is held. Changes to them while it runs do not alter any output until the next release.
- R9: With `osc_en_n`=1 the divider chain is clocked by `ref_clk` instead of `osc_clk`.
- R10: Every output has a 50% duty cycle. It is high for the first half of each period, counted in ticks from the first tick, and low for the second half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator (fast source) clock |
| ref_clk | input | 1 | Reference clock, used when the oscillator path is bypassed |
| osc_en_n | input | 1 | Low: chain runs on `osc_clk`; high: chain runs on `ref_clk` |
| mr_oe | input | 1 | High: clear dividers, park outputs, disable banks; low: run |
| pre_sel | input | 1 | 1 enables the divide-by-two prescaler |
| sel_a | input | 1 | Bank A ratio select (0: /4, 1: /6) |
| sel_b | input | 1 | Bank B ratio select (0: /4, 1: /2) |
| sel_c | input | 1 | Bank C ratio select (0: /2, 1: /4) |
| qa | output | 5 | Bank A clock outputs |
| qb | output | 4 | Bank B clock outputs |
| qc | output | 2 | Bank C clock outputs |
| oe_a | output | 1 | Bank A output enable |
| oe_b | output | 1 | Bank B output enable |
| oe_c | output | 1 | Bank C output enable |

## Verification
Call the first chain edge after `mr_oe` falls edge 0. The enables are due after edge 0, and the first high level of every output is due after edge 1. After that, a bank with ratio R and step s (1 without the prescaler, 2 with it) shows, after edge k, the level for tick index (k-1)/s: high when that index modulo R is below R/2. The bench releases reset just after a falling chain edge and samples on every following falling chain edge. Sample k therefore lines up exactly with edge k, and each bank's whole sampled waveform is compared against this formula. The same falling edge of whichever clock feeds the chain is used in bypass runs, so a period counted in reference-clock cycles shows which clock drove the dividers.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int NUM_BANKS = 3;

  typedef struct packed {
    logic                 pre;
    logic [NUM_BANKS-1:0] sel;
  } cfg_t;
endpackage

// File: rtl/bcd_clk_pick.sv
module bcd_clk_pick (
  input  logic osc_clk,
  input  logic ref_clk,
  input  logic use_ref,
  output logic cclk
);
  // Source choice is only changed while the chain is held in reset.
  assign cclk = use_ref ? ref_clk : osc_clk;
endmodule

// File: rtl/bcd_ctl.sv
module bcd_ctl
  import bcd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pre_in,
  input  logic [NUM_BANKS-1:0] sel_in,
  output logic                 run,
  output logic                 tick,
  output cfg_t                 cfg
);
  logic tog;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) run <= 1'b0;
    else     run <= 1'b1;
  end

  // Configuration follows the pins until the first running edge, then freezes.
  always_ff @(posedge clk) begin
    if (!run) begin
      cfg.pre <= pre_in;
      cfg.sel <= sel_in;
    end
  end

  // Prescale phase: a tick on the first running edge, then every second edge.
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                 tog <= 1'b0;
    else if (run && cfg.pre) tog <= ~tog;
  end

  assign tick = run && (!cfg.pre || !tog);
endmodule

// File: rtl/bcd_bank.sv
module bcd_bank #(
  parameter int OUTS   = 4,
  parameter int RATIO0 = 4,
  parameter int RATIO1 = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            sel,
  output logic [OUTS-1:0] q
);
  localparam int RMAX = (RATIO0 > RATIO1) ? RATIO0 : RATIO1;
  localparam int CW   = (RMAX > 2) ? $clog2(RMAX) : 1;

  logic [CW-1:0] phase;
  logic [CW-1:0] last;
  logic [CW-1:0] half;
  logic          lvl;

  always_comb begin
    last = sel ? CW'(RATIO1 - 1) : CW'(RATIO0 - 1);
    half = sel ? CW'(RATIO1 / 2) : CW'(RATIO0 / 2);
  end

  // High for ticks 0..half-1 of each period, low for the rest.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase <= '0;
      lvl   <= 1'b0;
    end else if (tick) begin
      lvl   <= (phase < half);
      phase <= (phase == last) ? '0 : phase + 1'b1;
    end
  end

  for (genvar g = 0; g < OUTS; g++) begin : g_fan
    assign q[g] = lvl;
  end
endmodule

// File: rtl/bank_clk_div.sv
module bank_clk_div
  import bcd_pkg::*;
#(
  parameter int A_OUTS   = 5,
  parameter int B_OUTS   = 4,
  parameter int C_OUTS   = 2,
  parameter int A_RATIO0 = 4,
  parameter int A_RATIO1 = 6,
  parameter int B_RATIO0 = 4,
  parameter int B_RATIO1 = 2,
  parameter int C_RATIO0 = 2,
  parameter int C_RATIO1 = 4
) (
  input  logic              osc_clk,
  input  logic              ref_clk,
  input  logic              osc_en_n,
  input  logic              mr_oe,
  input  logic              pre_sel,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              sel_c,
  output logic [A_OUTS-1:0] qa,
  output logic [B_OUTS-1:0] qb,
  output logic [C_OUTS-1:0] qc,
  output logic              oe_a,
  output logic              oe_b,
  output logic              oe_c
);
  logic cclk;
  logic run;
  logic tick;
  cfg_t cfg;

  bcd_clk_pick u_pick (
    .osc_clk (osc_clk),
    .ref_clk (ref_clk),
    .use_ref (osc_en_n),
    .cclk    (cclk)
  );

  bcd_ctl u_ctl (
    .clk    (cclk),
    .rst    (mr_oe),
    .pre_in (pre_sel),
    .sel_in ({sel_c, sel_b, sel_a}),
    .run    (run),
    .tick   (tick),
    .cfg    (cfg)
  );

  bcd_bank #(.OUTS(A_OUTS), .RATIO0(A_RATIO0), .RATIO1(A_RATIO1)) u_bank_a (
    .clk (cclk), .rst (mr_oe), .tick (tick), .sel (cfg.sel[0]), .q (qa)
  );

  bcd_bank #(.OUTS(B_OUTS), .RATIO0(B_RATIO0), .RATIO1(B_RATIO1)) u_bank_b (
    .clk (cclk), .rst (mr_oe), .tick (tick), .sel (cfg.sel[1]), .q (qb)
  );

  bcd_bank #(.OUTS(C_OUTS), .RATIO0(C_RATIO0), .RATIO1(C_RATIO1)) u_bank_c (
    .clk (cclk), .rst (mr_oe), .tick (tick), .sel (cfg.sel[2]), .q (qc)
  );

  assign oe_a = run;
  assign oe_b = run;
  assign oe_c = run;
endmodule

// File: rtl/bcd_chk.sv
module bcd_chk #(
  parameter int A_OUTS = 5,
  parameter int B_OUTS = 4,
  parameter int C_OUTS = 2,
  parameter int CFG_W  = 4
) (
  input logic              cclk,
  input logic              mr_oe,
  input logic [A_OUTS-1:0] qa,
  input logic [B_OUTS-1:0] qb,
  input logic [C_OUTS-1:0] qc,
  input logic              oe_a,
  input logic              oe_b,
  input logic              oe_c,
  input logic [CFG_W-1:0]  cfg_q
);
  p_bank_uniform_r1: assert property (@(posedge cclk) disable iff (mr_oe)
    (qa == '0 || qa == '1) && (qb == '0 || qb == '1) && (qc == '0 || qc == '1));

  p_oe_release_r6: assert property (@(posedge cclk) disable iff (mr_oe)
    !mr_oe |=> (oe_a && oe_b && oe_c));

  p_quiet_before_run_r6: assert property (@(posedge cclk) disable iff (mr_oe)
    !oe_a |-> (qa == '0 && qb == '0 && qc == '0));

  p_first_rise_r7: assert property (@(posedge cclk) disable iff (mr_oe)
    $rose(oe_a) |=> (qa[0] && qb[0] && qc[0]));

  p_cfg_frozen_r8: assert property (@(posedge cclk) disable iff (mr_oe)
    (oe_a && $past(oe_a)) |-> $stable(cfg_q));

  p_a_high_two_r2: assert property (@(posedge cclk) disable iff (mr_oe)
    $rose(qa[0]) |=> qa[0]);
endmodule

bind bank_clk_div bcd_chk #(
  .A_OUTS (A_OUTS),
  .B_OUTS (B_OUTS),
  .C_OUTS (C_OUTS),
  .CFG_W  (bcd_pkg::NUM_BANKS + 1)
) i_chk (
  .cclk  (cclk),
  .mr_oe (mr_oe),
  .qa    (qa),
  .qb    (qb),
  .qc    (qc),
  .oe_a  (oe_a),
  .oe_b  (oe_b),
  .oe_c  (oe_c),
  .cfg_q (cfg)
);

// File: tb/test_bank_clk_div.sv
module test_bank_clk_div;
  localparam int K = 48;

  logic       osc_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       osc_en_n = 1'b0;
  logic       mr_oe = 1'b0;
  logic       pre_sel = 1'b0;
  logic       sel_a = 1'b0;
  logic       sel_b = 1'b0;
  logic       sel_c = 1'b0;
  logic [4:0] qa;
  logic [3:0] qb;
  logic [1:0] qc;
  logic       oe_a, oe_b, oe_c;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #4ns  osc_clk = ~osc_clk;
  always #10ns ref_clk = ~ref_clk;

  bank_clk_div i_bank_clk_div (
    .osc_clk (osc_clk), .ref_clk (ref_clk), .osc_en_n (osc_en_n), .mr_oe (mr_oe),
    .pre_sel (pre_sel), .sel_a (sel_a), .sel_b (sel_b), .sel_c (sel_c),
    .qa (qa), .qb (qb), .qc (qc), .oe_a (oe_a), .oe_b (oe_b), .oe_c (oe_c)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chain_neg(input bit use_ref);
    if (use_ref) @(negedge ref_clk);
    else         @(negedge osc_clk);
  endtask

  function automatic bit exp_lvl(input int k, input int ratio, input int step);
    int j;
    if (k == 0) return 1'b0;
    j = (k - 1) / step;
    return (j % ratio) < (ratio / 2);
  endfunction

  // Hold, configure, release, then compare K samples per bank against the formula.
  task automatic run_cfg(input bit pre, input bit sa, input bit sb, input bit sc,
                         input bit use_ref, input int flip_at, input string tag);
    int  ra, rb, rc, st;
    bit  bad_a, bad_b, bad_c, bad_u;
    int  act_a, exp_a, act_b, exp_b, act_c, exp_c;
    ra = sa ? 6 : 4;
    rb = sb ? 2 : 4;
    rc = sc ? 4 : 2;
    st = pre ? 2 : 1;
    bad_a = 0; bad_b = 0; bad_c = 0; bad_u = 0;
    act_a = 0; exp_a = 0; act_b = 0; exp_b = 0; act_c = 0; exp_c = 0;
    mr_oe = 1'b1;
    osc_en_n = use_ref;
    pre_sel = pre; sel_a = sa; sel_b = sb; sel_c = sc;
    for (int i = 0; i < 3; i++) chain_neg(use_ref);
    mr_oe = 1'b0;
    for (int k = 0; k < K; k++) begin
      chain_neg(use_ref);
      if (k == 0) check(oe_a && oe_b && oe_c, {"R6 enables after release ", tag},
                        {oe_a, oe_b, oe_c}, 7);
      if (k == 1) check(qa[0] && qb[0] && qc[0], {"R7 first rise together ", tag},
                        {qa[0], qb[0], qc[0]}, 7);
      if (!(qa == '0 || qa == '1) || !(qb == '0 || qb == '1) || !(qc == '0 || qc == '1))
        bad_u = 1;
      if (!bad_a && qa[0] != exp_lvl(k, ra, st)) begin
        bad_a = 1; act_a = k * 2 + qa[0]; exp_a = k * 2 + exp_lvl(k, ra, st);
      end
      if (!bad_b && qb[0] != exp_lvl(k, rb, st)) begin
        bad_b = 1; act_b = k * 2 + qb[0]; exp_b = k * 2 + exp_lvl(k, rb, st);
      end
      if (!bad_c && qc[0] != exp_lvl(k, rc, st)) begin
        bad_c = 1; act_c = k * 2 + qc[0]; exp_c = k * 2 + exp_lvl(k, rc, st);
      end
      if (k == flip_at) begin
        pre_sel = ~pre; sel_a = ~sa; sel_b = ~sb; sel_c = ~sc;
      end
    end
    // Values below encode 2*cycle + level at the first mismatch.
    check(!bad_u, {"R1 bank bits uniform ", tag}, bad_u, 0);
    check(!bad_a, {"R2/R5/R10 bank A waveform ", tag}, act_a, exp_a);
    check(!bad_b, {"R3/R5/R10 bank B waveform ", tag}, act_b, exp_b);
    check(!bad_c, {"R4/R5/R10 bank C waveform ", tag}, act_c, exp_c);
  endtask

  task automatic t_reset_state;
    mr_oe = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge osc_clk);
    check(qa == '0 && qb == '0 && qc == '0, "R6 outputs parked in reset", {qa, qb, qc}, 0);
    check(!oe_a && !oe_b && !oe_c, "R6 enables low in reset", {oe_a, oe_b, oe_c}, 0);
  endtask

  task automatic t_sweep;
    for (int c = 0; c < 16; c++) begin
      run_cfg(c[3], c[0], c[1], c[2], 1'b0, -1, $sformatf("R5 pre=%0d sel=%0d", c[3], c[2:0]));
    end
  endtask

  task automatic t_reset_midrun;
    run_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, -1, "pre-midrun");
    mr_oe = 1'b1;
    #1ns;
    check(qa == '0 && qb == '0 && qc == '0 && !oe_a, "R6 mid-run reset clears",
          {qa, qb, qc, oe_a}, 0);
  endtask

  task automatic t_hold_select;
    run_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10, "R8 selects flipped while running");
    run_cfg(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5, "R8 new selects after release");
  endtask

  task automatic t_ref_bypass;
    run_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, -1, "R9 reference clock drives chain");
    run_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, -1, "R9 reference clock with prescaler");
  endtask

  initial begin
    #1ns mr_oe = 1'b1;
    t_reset_state();
    t_sweep();
    t_reset_midrun();
    t_hold_select();
    t_ref_bypass();
    mr_oe = 1'b1;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #500us;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule